// File: doc/BRIEF.md
# Word-Mode Bitmap Fill and Shift Engine

This engine walks a run of bitmap words in one plane of display memory and rewrites each word in place. Software sets up an operation, a direction, a pattern bit, a starting X/Y position and a word count, then pulses `start`. For every word the engine reads the word, computes the new value, writes it back to the same address and pulses an invalidate output carrying that address. A display cache can use that pulse to drop its stale copy. The `done` output stays high while the engine is idle.

The operations are complement, solid fill, inverted solid fill and a shift by 1, 2 or 4 bits. In a shift, the bits that leave one word enter the next word of the run. A single direction input selects two things together: whether the shift goes left or right, and whether the address counts up or down. This lets one run scroll a horizontal span of pixels by a few bits.

Top module: `wordeng_top`

## Requirements
- R1: After reset `done` is 1 and `memRdEn`, `memWrEn` and `invValid` are 0.
- R2: The first word of a run is at index {yPos, xPos[9:4]}. The low four bits of `xPos` have no effect.
- R3: Each word takes two cycles: a read cycle (`memRdEn`=1), then a write cycle at the same `memAddr`. In the write cycle `invValid`=1 and `invIndex` equals that address.
- R4: `opSel`=1 (complement) writes the bitwise inverse of the word that was read.
- R5: The fill value is all ones when `patBit` is 1 and all zeros when it is 0. `opSel`=2 writes the fill value and `opSel`=3 writes its inverse.
- R6: `opSel`=0 or 7 (no operation) never asserts `memWrEn` and leaves memory unchanged. It still produces one invalidate pulse per word.
- R7: With `dirRtl`=0, `opSel`=4/5/6 shifts the word left by 1/2/4 bits. The vacated low bits take the top bits of the carry word.
- R8: With `dirRtl`=1, the shift ops shift right by 1/2/4 bits. The vacated high bits take the bottom bits of the carry word.
- R9: The carry word starts each run as the fill value and is then loaded with each shifted word's original contents. The index rises by one per word when `dirRtl`=0 and falls by one when `dirRtl`=1. It wraps modulo 2^(Y_W+X_W-4).
- R10: `done` falls in the cycle after an accepted start with a nonzero count. It rises again exactly 2*count cycles after the start edge, one cycle after the last write.
- R11: A start with `runCount`=0 causes no memory access and no invalidate, and `done` stays 1.
- R12: A `start` pulse while a run is in progress is ignored, including any change to the operation inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run when idle |
| runCount | input | CNT_W | Number of words in the run |
| opSel | input | 3 | Operation code (see R4 to R8) |
| dirRtl | input | 1 | 0: left shift, rising index; 1: right shift, falling index |
| patBit | input | 1 | Selects the solid fill value |
| xPos | input | X_W | Pixel X of the first word |
| yPos | input | Y_W | Line of the first word |
| memAddr | output | Y_W+X_W-4 | Word index for read and write |
| memRdEn | output | 1 | Read request; data returns the next cycle |
| memRdData | input | WORD_W | Read data, valid the cycle after `memRdEn` |
| memWrEn | output | 1 | Write strobe |
| memWrData | output | WORD_W | Write data |
| invValid | output | 1 | Cache invalidate pulse |
| invIndex | output | Y_W+X_W-4 | Index being invalidated |
| done | output | 1 | Engine idle |

## Verification
Some rules hold on every cycle, and the embedded properties check them all the time: every write follows a read of the same address; the index steps by exactly one in the selected direction; a solid fill writes only all-zero or all-one words; no access occurs while `done` is high; `done` rises only after a write cycle; and a zero-count start leaves the engine idle. Other behaviour shows only at the end of a run, so only the bench scenarios can demonstrate it: the exact data written by each shift with its word-to-word carry, wrap-around at both ends of the index space, the exact latency of `done`, and a mid-run start being rejected.

// File: rtl/wordeng_pkg.sv
package wordeng_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_COM   = 3'd1,
    OP_MOVE  = 3'd2,
    OP_NMOVE = 3'd3,
    OP_SH1   = 3'd4,
    OP_SH2   = 3'd5,
    OP_SH4   = 3'd6,
    OP_RSV   = 3'd7
  } wordOp_e;

  typedef struct packed {
    logic load;
    logic rdStb;
    logic wrStb;
    logic step;
  } ctlStb_t;

endpackage

// File: rtl/wordeng_ctl.sv
module wordeng_ctl
  import wordeng_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] runCount,
  output ctlStb_t          stb,
  output logic             done
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_e;

  state_e            state;
  logic [CNT_W-1:0]  remain;
  logic              accept;

  assign accept = (state == S_IDLE) && start && (runCount != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      remain <= '0;
      done   <= 1'b1;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          remain <= runCount;
          state  <= S_RD;
          done   <= 1'b0;
        end
        S_RD: state <= S_WR;
        S_WR: begin
          if (remain == CNT_W'(1)) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            remain <= remain - 1'b1;
            state  <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.load  = accept;
    stb.rdStb = (state == S_RD);
    stb.wrStb = (state == S_WR);
    stb.step  = (state == S_WR);
  end

  // R10: memory is never touched while the engine reports idle
  p_no_access_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStb || stb.wrStb) |-> !done);

  // R10: done only rises right after a write cycle
  p_done_after_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(stb.wrStb));

  // R11: zero-length run leaves the engine idle
  p_zero_run_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && runCount == '0) |=> (done && state == S_IDLE));

endmodule

// File: rtl/wordeng_dp.sv
module wordeng_dp
  import wordeng_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int X_W    = 10,
  parameter int Y_W    = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStb_t                        stb,
  input  logic [2:0]                     opSel,
  input  logic                           dirRtl,
  input  logic                           patBit,
  input  logic [X_W-1:0]                 xPos,
  input  logic [Y_W-1:0]                 yPos,
  input  logic [WORD_W-1:0]              memRdData,
  output logic [Y_W+X_W-$clog2(WORD_W)-1:0] memAddr,
  output logic                           memRdEn,
  output logic                           memWrEn,
  output logic [WORD_W-1:0]              memWrData,
  output logic                           invValid,
  output logic [Y_W+X_W-$clog2(WORD_W)-1:0] invIndex
);

  localparam int COL_SH = $clog2(WORD_W);
  localparam int ADDR_W = Y_W + X_W - COL_SH;

  logic [ADDR_W-1:0] idxQ;
  wordOp_e           opQ;
  logic              dirQ;
  logic [WORD_W-1:0] fillQ;
  logic [WORD_W-1:0] shInQ;
  logic [WORD_W-1:0] wrWord;
  logic              isShift;
  logic              xLowUnused;

  assign xLowUnused = ^xPos[COL_SH-1:0];

  function automatic logic [WORD_W-1:0] shiftWord(
    input logic [WORD_W-1:0] w,
    input logic [WORD_W-1:0] si,
    input int unsigned       n,
    input logic              rtl
  );
    if (rtl) return (w >> n) | (si << (WORD_W - n));
    else     return (w << n) | (si >> (WORD_W - n));
  endfunction

  assign isShift = (opQ == OP_SH1) || (opQ == OP_SH2) || (opQ == OP_SH4);

  always_comb begin
    unique case (opQ)
      OP_COM:   wrWord = ~memRdData;
      OP_MOVE:  wrWord = fillQ;
      OP_NMOVE: wrWord = ~fillQ;
      OP_SH1:   wrWord = shiftWord(memRdData, shInQ, 1, dirQ);
      OP_SH2:   wrWord = shiftWord(memRdData, shInQ, 2, dirQ);
      OP_SH4:   wrWord = shiftWord(memRdData, shInQ, 4, dirQ);
      default:  wrWord = memRdData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ  <= '0;
      opQ   <= OP_NOP;
      dirQ  <= 1'b0;
      fillQ <= '0;
      shInQ <= '0;
    end else if (stb.load) begin
      idxQ  <= {yPos, xPos[X_W-1:COL_SH]};
      opQ   <= wordOp_e'(opSel);
      dirQ  <= dirRtl;
      fillQ <= {WORD_W{patBit}};
      shInQ <= {WORD_W{patBit}};
    end else if (stb.step) begin
      idxQ <= dirQ ? idxQ - 1'b1 : idxQ + 1'b1;
      if (isShift) shInQ <= memRdData;
    end
  end

  assign memAddr   = idxQ;
  assign invIndex  = idxQ;
  assign memRdEn   = stb.rdStb;
  assign invValid  = stb.wrStb;
  assign memWrEn   = stb.wrStb && (opQ != OP_NOP) && (opQ != OP_RSV);
  assign memWrData = wrWord;

  // R3: a write lands on the address read in the previous cycle
  p_same_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStb |-> ($past(stb.rdStb) && memAddr == $past(memAddr)));

  // R9: index moves by exactly one in the chosen direction
  p_walk_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.step) |-> (idxQ == (dirQ ? ADDR_W'($past(idxQ) - 1'b1)
                                       : ADDR_W'($past(idxQ) + 1'b1))));

  // R5: a solid fill writes only all-zero or all-one words
  p_move_solid_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && opQ == OP_MOVE) |-> (memWrData == '0 || memWrData == '1));

endmodule

// File: rtl/wordeng_top.sv
module wordeng_top
  import wordeng_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int X_W    = 10,
  parameter int Y_W    = 5,
  parameter int CNT_W  = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              start,
  input  logic [CNT_W-1:0]                  runCount,
  input  logic [2:0]                        opSel,
  input  logic                              dirRtl,
  input  logic                              patBit,
  input  logic [X_W-1:0]                    xPos,
  input  logic [Y_W-1:0]                    yPos,
  output logic [Y_W+X_W-$clog2(WORD_W)-1:0] memAddr,
  output logic                              memRdEn,
  input  logic [WORD_W-1:0]                 memRdData,
  output logic                              memWrEn,
  output logic [WORD_W-1:0]                 memWrData,
  output logic                              invValid,
  output logic [Y_W+X_W-$clog2(WORD_W)-1:0] invIndex,
  output logic                              done
);

  ctlStb_t stb;

  wordeng_ctl #(.CNT_W(CNT_W)) ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .runCount (runCount),
    .stb      (stb),
    .done     (done)
  );

  wordeng_dp #(.WORD_W(WORD_W), .X_W(X_W), .Y_W(Y_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .opSel     (opSel),
    .dirRtl    (dirRtl),
    .patBit    (patBit),
    .xPos      (xPos),
    .yPos      (yPos),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .memWrData (memWrData),
    .invValid  (invValid),
    .invIndex  (invIndex)
  );

endmodule

// File: tb/wordeng_tb_top.sv
module wordeng_tb_top;

  localparam int WORD_W = 16;
  localparam int X_W    = 10;
  localparam int Y_W    = 5;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = Y_W + X_W - 4;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic [2:0]  op;
    logic        dir;
    logic        pat;
    logic [9:0]  x;
    logic [4:0]  y;
    logic [7:0]  cnt;
    logic [15:0] seed;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{3'd1, 1'b0, 1'b0, 10'h013, 5'd3,  8'd5, 16'h1234},
    '{3'd2, 1'b0, 1'b1, 10'h3F5, 5'd31, 8'd3, 16'hA5A5},
    '{3'd2, 1'b1, 1'b0, 10'h02F, 5'd0,  8'd4, 16'h0F0F},
    '{3'd3, 1'b0, 1'b1, 10'h100, 5'd7,  8'd6, 16'h5555},
    '{3'd4, 1'b0, 1'b1, 10'h208, 5'd12, 8'd4, 16'hC3C3},
    '{3'd5, 1'b1, 1'b0, 10'h0A0, 5'd9,  8'd4, 16'h7E81},
    '{3'd6, 1'b0, 1'b0, 10'h3C0, 5'd20, 8'd5, 16'h1357},
    '{3'd6, 1'b1, 1'b1, 10'h050, 5'd1,  8'd3, 16'h2468},
    '{3'd0, 1'b0, 1'b1, 10'h111, 5'd5,  8'd4, 16'hFACE},
    '{3'd4, 1'b1, 1'b0, 10'h07F, 5'd30, 8'd1, 16'hBEEF},
    '{3'd7, 1'b1, 1'b0, 10'h00F, 5'd0,  8'd2, 16'h0BAD}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] runCount = '0;
  logic [2:0] opSel = '0;
  logic dirRtl = 1'b0;
  logic patBit = 1'b0;
  logic [X_W-1:0] xPos = '0;
  logic [Y_W-1:0] yPos = '0;
  logic [ADDR_W-1:0] memAddr;
  logic memRdEn;
  logic [WORD_W-1:0] memRdData;
  logic memWrEn;
  logic [WORD_W-1:0] memWrData;
  logic invValid;
  logic [ADDR_W-1:0] invIndex;
  logic done;

  always #10 clk = ~clk;

  wordeng_top #(.WORD_W(WORD_W), .X_W(X_W), .Y_W(Y_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .runCount(runCount), .opSel(opSel),
    .dirRtl(dirRtl), .patBit(patBit), .xPos(xPos), .yPos(yPos),
    .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrData(memWrData), .invValid(invValid),
    .invIndex(invIndex), .done(done)
  );

  function automatic logic [15:0] wordInit(input int i, input logic [15:0] s);
    return 16'(i * 40503) ^ s ^ 16'(i << 5);
  endfunction

  // memory model, one-cycle read latency
  logic [15:0] mem [DEPTH];
  logic [15:0] expMem [DEPTH];
  logic initMem = 1'b0;
  logic [15:0] initSeed = '0;

  always @(posedge clk) begin
    if (initMem) begin
      for (int i = 0; i < DEPTH; i++) mem[i] = wordInit(i, initSeed);
    end else begin
      if (memRdEn) memRdData <= mem[memAddr];
      if (memWrEn) mem[memAddr] = memWrData;
    end
  end

  // invalidate monitor
  logic clrStats = 1'b0;
  logic [ADDR_W-1:0] expFirst = '0;
  logic expDir = 1'b0;
  int invSeen;
  int invBad;

  always_ff @(posedge clk) begin
    if (clrStats) begin
      invSeen <= 0;
      invBad  <= 0;
    end else if (invValid) begin
      if (invIndex != (expDir ? ADDR_W'(expFirst - ADDR_W'(invSeen))
                              : ADDR_W'(expFirst + ADDR_W'(invSeen))))
        invBad <= invBad + 1;
      invSeen <= invSeen + 1;
    end
  end

  int nTests = 0;
  int nFail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string reqFor(input logic [2:0] op, input logic dir);
    case (op)
      3'd1: return "R4";
      3'd2, 3'd3: return "R5";
      3'd4, 3'd5, 3'd6: return dir ? "R8 R9" : "R7 R9";
      default: return "R6";
    endcase
  endfunction

  // independent reference of one run on expMem
  task automatic refRun(input vec_t v);
    logic [ADDR_W-1:0] idx = {v.y, v.x[9:4]};
    logic [15:0] fill = {16{v.pat}};
    logic [15:0] si = fill;
    logic [15:0] w;
    int n;
    for (int k = 0; k < int'(v.cnt); k++) begin
      w = expMem[idx];
      n = (v.op == 3'd4) ? 1 : (v.op == 3'd5) ? 2 : 4;
      case (v.op)
        3'd1: expMem[idx] = ~w;
        3'd2: expMem[idx] = fill;
        3'd3: expMem[idx] = ~fill;
        3'd4, 3'd5, 3'd6: begin
          if (v.dir) expMem[idx] = (w >> n) | (si << (16 - n));
          else       expMem[idx] = (w << n) | (si >> (16 - n));
          si = w;
        end
        default: ;
      endcase
      idx = v.dir ? idx - 1'b1 : idx + 1'b1;
    end
  endtask

  task automatic prepMem(input logic [15:0] s);
    @(negedge clk);
    initSeed = s;
    initMem = 1'b1;
    @(negedge clk);
    initMem = 1'b0;
    for (int i = 0; i < DEPTH; i++) expMem[i] = wordInit(i, s);
  endtask

  task automatic drive(input vec_t v);
    opSel = v.op; dirRtl = v.dir; patBit = v.pat;
    xPos = v.x; yPos = v.y; runCount = v.cnt;
  endtask

  task automatic memCompare(input string req, input string what);
    int bad = 0;
    int firstBad = -1;
    for (int i = 0; i < DEPTH; i++)
      if (mem[i] !== expMem[i]) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
    chk(bad == 0, req, what, bad, 0);
    if (bad != 0)
      $display("  first mismatch at %0d: %h vs %h", firstBad, mem[firstBad], expMem[firstBad]);
  endtask

  // launch a run at a negedge, return edges until done
  task automatic runVec(input vec_t v, input bit busyPoke, output int cyc);
    vec_t other;
    other = '{3'd1, ~v.dir, ~v.pat, ~v.x, ~v.y, 8'd2, 16'h0};
    expFirst = {v.y, v.x[9:4]};
    expDir = v.dir;
    clrStats = 1'b1;
    @(negedge clk);
    clrStats = 1'b0;
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      if (busyPoke && cyc == 2) begin
        drive(other);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
  endtask

  initial begin
    int cyc;
    bit sawAccess;
    vec_t busyVec;
    vec_t zeroVec;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done === 1'b1, "R1", "done after reset", done, 1);
    chk(memRdEn === 1'b0 && memWrEn === 1'b0 && invValid === 1'b0, "R1",
        "strobes idle in reset", {memRdEn, memWrEn, invValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(done === 1'b1 && memRdEn === 1'b0, "R1", "idle after reset release",
        {done, memRdEn}, 2);

    // vector table
    for (int k = 0; k < NVEC; k++) begin
      prepMem(VECS[k].seed);
      refRun(VECS[k]);
      runVec(VECS[k], 1'b0, cyc);
      @(negedge clk);
      memCompare(reqFor(VECS[k].op, VECS[k].dir), $sformatf("memory after vector %0d", k));
      chk(invSeen == int'(VECS[k].cnt) && invBad == 0, "R2 R3 R9",
          $sformatf("invalidate sequence vector %0d (bad=%0d)", k, invBad),
          invSeen, VECS[k].cnt);
      chk(cyc == 2 * int'(VECS[k].cnt), "R10",
          $sformatf("done latency vector %0d", k), cyc, 2 * VECS[k].cnt);
    end

    // R11: zero count
    zeroVec = '{3'd2, 1'b0, 1'b1, 10'h040, 5'd4, 8'd0, 16'h3333};
    prepMem(zeroVec.seed);
    @(negedge clk);
    drive(zeroVec);
    start = 1'b1;
    sawAccess = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (memRdEn || memWrEn || invValid || !done) sawAccess = 1'b1;
    end
    chk(!sawAccess, "R11", "zero count access or busy", sawAccess, 0);
    memCompare("R11", "memory after zero count");

    // R12: start during a run is ignored
    busyVec = '{3'd2, 1'b0, 1'b1, 10'h200, 5'd10, 8'd4, 16'h6789};
    prepMem(busyVec.seed);
    refRun(busyVec);
    runVec(busyVec, 1'b1, cyc);
    @(negedge clk);
    memCompare("R12", "memory after start while busy");
    chk(cyc == 8, "R12", "latency unaffected by start while busy", cyc, 8);
    chk(invSeen == 4 && invBad == 0, "R12", "invalidates unaffected by start while busy",
        invSeen, 4);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests + 1, nFail + 1);
    $finish;
  end

endmodule